// File: doc/BRIEF.md
# Serial Port Buffer and Event Unit

This block holds the data and interrupt state of a serial port controller between a simple register bus and the serial shift engine. Software writes outgoing words into a transmit queue and reads incoming words from a receive queue. The engine takes words from the transmit queue and delivers received words into the receive queue through a small strobe interface. Clock generation and bit shifting belong to the engine, which is outside this block.

Both queues hold 32 bytes. A control register selects 8-bit or 16-bit words. In 16-bit mode each entry uses two bytes, so a queue holds 16 entries instead of 32. Each queue reports its fill level in bytes. Writing zero to a level register empties that queue. The receive side can flag when it holds at least a chosen number of words. That number is a power of two selected by a 3-bit code.

Six event sources latch into a status register. Software clears a status bit by writing a one to it. Each source has its own enable bit, and the interrupt line is raised when any latched event has its enable set.

Top module: `sbuf_evt`

## Requirements
- R1: After reset the control register, the status register and both levels read 0, `irq` is low and `eng_tx_avail` is low. Register addresses are: 0 control, 1 status, 2 transmit level, 3 receive level, 4 transmit data (write), 5 receive data (read).
- R2: Each queue is first-in first-out and holds 32 bytes. Control bit 20 set selects 16-bit words: 16 entries, and the level in bytes is twice the entry count. With bit 20 clear, 8-bit words are used: 32 entries, the level equals the entry count, and stored data is cut to its low 8 bits.
- R3: A word written to the transmit data address while the transmit queue is full is dropped. The level and the queued words do not change.
- R4: A bus read of the receive data address while the receive queue is empty returns 0 and leaves the level at 0.
- R5: Writing 0 to the transmit level address empties the transmit queue. Writing any other value there has no effect.
- R6: Writing 0 to the receive level address empties the receive queue. Writing any other value there has no effect.
- R7: Control bits 26:24 hold a trigger code c. Codes above 5 act as 5. Status bit 0 is set when control bit 16 is set and the receive queue holds at least 2^c words. With bit 16 clear, status bit 0 is never set.
- R8: Status bit 9 is set when the engine takes the last transmit word. Status bit 4 is set when an engine take brings the transmit count down from one above half capacity to half capacity.
- R9: A pulse on `eng_done` sets status bit 8.
- R10: A word arriving on `eng_rx_valid` while the receive queue is full is dropped and sets status bit 12.
- R11: `eng_tx_req` while the transmit queue is empty sets status bit 13. `eng_tx_avail` is low whenever the queue is empty.
- R12: Writing the status address clears each of bits 0, 4, 8, 9, 12 and 13 that is written as 1. Bits written as 0 are kept. A new event in the same cycle as its clear leaves the bit set.
- R13: Control bits 0, 4, 8, 9, 12 and 13 enable the status bit at the same position. `irq` is high exactly when some status bit and its enable are both 1. Status bits latch whether or not they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_tx_req | input | 1 | Engine takes the head transmit word |
| eng_tx_word | output | 16 | Head transmit word |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_valid | input | 1 | Engine delivers a received word |
| eng_rx_word | input | 16 | Received word |
| eng_done | input | 1 | Transfer end pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the receive trigger compare at its exact boundary. Every trigger code has to be tried in both word widths, with the gate on and off, and the check has to land on the word that makes the count reach the threshold. The bench sweeps all eight codes in both widths and both gate settings. Each time it empties the queue, clears the status register, and then feeds words one at a time until the queue is full, checking bit 0 after every word. It then feeds one more word to force an overflow, and drains the queue to confirm that the dropped word never appears.

// File: rtl/sbuf_evt.sv
module sbuf_evt #(
  parameter int DEPTH_BYTES = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_tx_req,
  output logic [WORD_W-1:0] eng_tx_word,
  output logic              eng_tx_avail,
  input  logic              eng_rx_valid,
  input  logic [WORD_W-1:0] eng_rx_word,
  input  logic              eng_done,
  output logic              irq
);
  localparam int AW = $clog2(DEPTH_BYTES);
  localparam int CW = AW + 1;
  localparam logic [2:0] MAXCODE = 3'(AW);
  localparam logic [31:0] EVT_MASK  = 32'h0000_3311;
  localparam logic [31:0] CTRL_MASK = EVT_MASK | 32'h0711_0000;
  localparam logic [2:0] A_CTL = 3'd0, A_ST = 3'd1, A_TXL = 3'd2,
                         A_RXL = 3'd3, A_TXD = 3'd4, A_RXD = 3'd5;

  logic [31:0] ctrl_q, status_q, ev, clr;
  logic [WORD_W-1:0] tx_mem [DEPTH_BYTES];
  logic [WORD_W-1:0] rx_mem [DEPTH_BYTES];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wide = ctrl_q[20];
  wire [WORD_W-1:0] mask = wide ? {WORD_W{1'b1}} : WORD_W'(8'hFF);
  wire [CW-1:0] cap  = wide ? CW'(DEPTH_BYTES / 2) : CW'(DEPTH_BYTES);
  wire [CW-1:0] half = cap >> 1;
  wire [2:0] code = (ctrl_q[26:24] > MAXCODE) ? MAXCODE : ctrl_q[26:24];
  wire [CW-1:0] thr = CW'(1) << code;

  wire tx_flush = bus_wr && bus_addr == A_TXL && bus_wdata == 32'd0;
  wire rx_flush = bus_wr && bus_addr == A_RXL && bus_wdata == 32'd0;
  wire tx_push  = bus_wr && bus_addr == A_TXD && tx_cnt < cap;
  wire tx_pop   = eng_tx_req && tx_cnt != '0;
  wire rx_push  = eng_rx_valid && rx_cnt < cap;
  wire rx_pop   = bus_rd && bus_addr == A_RXD && rx_cnt != '0;

  assign eng_tx_avail = tx_cnt != '0;
  assign eng_tx_word  = tx_mem[tx_rp];
  assign irq = |(status_q & ctrl_q & EVT_MASK);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[WORD_W-1:0] & mask;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_word & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_flush) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + AW'(1);
        if (tx_pop)  tx_rp <= tx_rp + AW'(1);
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      end
      if (rx_flush) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + AW'(1);
        if (rx_pop)  rx_rp <= rx_rp + AW'(1);
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
    end
  end

  always_comb begin
    ev = '0;
    ev[0]  = ctrl_q[16] && rx_cnt >= thr;
    ev[4]  = tx_pop && !tx_push && !tx_flush && tx_cnt == half + CW'(1);
    ev[8]  = eng_done;
    ev[9]  = tx_pop && !tx_push && !tx_flush && tx_cnt == CW'(1);
    ev[12] = eng_rx_valid && rx_cnt >= cap;
    ev[13] = eng_tx_req && tx_cnt == '0;
    clr = (bus_wr && bus_addr == A_ST) ? (bus_wdata & EVT_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      status_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTL) ctrl_q <= bus_wdata & CTRL_MASK;
      status_q <= (status_q & ~clr) | ev;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = ctrl_q;
      A_ST:    bus_rdata = status_q;
      A_TXL:   bus_rdata = 32'(tx_cnt) << wide;
      A_RXL:   bus_rdata = 32'(rx_cnt) << wide;
      A_RXD:   bus_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : 32'd0;
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH_BYTES) && rx_cnt <= CW'(DEPTH_BYTES));
  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXD && tx_cnt >= cap && !eng_tx_req) |=> $stable(tx_cnt));
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXD && rx_cnt == '0 && !eng_rx_valid) |=> rx_cnt == '0);
  assert_tx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXL && bus_wdata == 32'd0) |=> tx_cnt == '0);
  assert_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_cnt >= cap) |=> status_q[12]);
  assert_underrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_req && !eng_tx_avail) |=> status_q[13]);
  assert_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ST && bus_wdata[8] && !eng_done) |=> !status_q[8]);
endmodule

// File: tb/sbuf_evt_test.sv
module sbuf_evt_test;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_tx_req = 0, eng_tx_avail, eng_rx_valid = 0, eng_done = 0, irq;
  logic [15:0] eng_tx_word, eng_rx_word = 0;
  int total = 0, bad = 0;

  sbuf_evt uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_req(eng_tx_req), .eng_tx_word(eng_tx_word), .eng_tx_avail(eng_tx_avail),
    .eng_rx_valid(eng_rx_valid), .eng_rx_word(eng_rx_word), .eng_done(eng_done), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic eng_pop();
    @(negedge clk); eng_tx_req = 1; @(negedge clk); eng_tx_req = 0;
  endtask

  task automatic eng_push(logic [15:0] d);
    @(negedge clk); eng_rx_word = d; eng_rx_valid = 1; @(negedge clk); eng_rx_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] m;
    int cap, thr, w;
    repeat (3) tick();
    rst_n = 1;
    tick();
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 status", d, 0);
    rd(2, d); check("R1 txlvl", d, 0);
    rd(3, d); check("R1 rxlvl", d, 0);
    check("R1 irq", irq, 0);
    check("R1 avail", eng_tx_avail, 0);

    for (int wm = 0; wm < 2; wm++) begin
      w = wm; cap = w ? 16 : 32; m = w ? 16'hFFFF : 16'h00FF;
      wr(0, 32'(w) << 20);
      wr(2, 0);
      for (int i = 0; i < cap; i++) begin
        wr(4, 32'(16'hA500 + 16'(i * 3)));
        rd(2, d); check("R2 txlvl fill", d, 32'((i + 1) << w));
      end
      wr(4, 32'h0000_FFFF);
      rd(2, d); check("R3 txlvl full", d, 32);
      wr(1, 32'h3311);
      for (int i = 0; i < cap; i++) begin
        check("R2 tx order", 32'(eng_tx_word), 32'((16'hA500 + 16'(i * 3)) & m));
        eng_pop();
        rd(1, d);
        check("R8 half event", 32'(d[4]), 32'((cap - 1 - i) <= cap / 2));
        check("R8 empty event", 32'(d[9]), 32'((cap - 1 - i) == 0));
      end
      check("R3 extra word dropped", eng_tx_avail, 0);
      rd(1, d); check("R11 no underrun yet", 32'(d[13]), 0);
      eng_pop();
      rd(1, d); check("R11 underrun", 32'(d[13]), 1);
      check("R11 avail low", eng_tx_avail, 0);
    end

    for (int wm = 0; wm < 2; wm++) begin
      for (int g = 0; g < 2; g++) begin
        for (int c = 0; c < 8; c++) begin
          w = wm; cap = w ? 16 : 32; m = w ? 16'hFFFF : 16'h00FF;
          thr = 1 << ((c > 5) ? 5 : c);
          wr(0, (32'(g) << 16) | (32'(w) << 20) | (32'(c) << 24));
          wr(3, 0);
          tick();
          wr(1, 32'h3311);
          for (int k = 1; k <= cap; k++) begin
            eng_push(16'h5A00 + 16'(k * 7 + c));
            tick();
            rd(1, d);
            check("R7 rx trigger", 32'(d[0]), 32'(g == 1 && k >= thr));
          end
          rd(1, d); check("R10 no overflow yet", 32'(d[12]), 0);
          eng_push(16'hFFFF);
          rd(1, d); check("R10 overflow", 32'(d[12]), 1);
          rd(3, d); check("R10 level kept", d, 32);
          for (int k = 1; k <= cap; k++) begin
            rd(5, d);
            check("R2 rx order", d, 32'((16'h5A00 + 16'(k * 7 + c)) & m));
          end
          rd(5, d); check("R4 empty read", d, 0);
          rd(3, d); check("R4 level zero", d, 0);
        end
      end
    end

    wr(0, 0);
    for (int i = 0; i < 3; i++) wr(4, 32'(i + 1));
    wr(2, 5);
    rd(2, d); check("R5 nonzero ignored", d, 3);
    wr(2, 0);
    rd(2, d); check("R5 flushed", d, 0);
    check("R5 avail", eng_tx_avail, 0);
    for (int i = 0; i < 3; i++) eng_push(16'(i + 9));
    wr(3, 7);
    rd(3, d); check("R6 nonzero ignored", d, 3);
    wr(3, 0);
    rd(3, d); check("R6 flushed", d, 0);
    rd(5, d); check("R6 read after flush", d, 0);

    wr(1, 32'h3311);
    rd(1, d); check("R12 all cleared", d, 0);
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
    rd(1, d); check("R9 done", d, 32'h100);
    eng_pop();
    rd(1, d); check("R12 two set", d, 32'h2100);
    wr(1, 32'h100);
    rd(1, d); check("R12 partial clear", d, 32'h2000);
    @(negedge clk); bus_addr = 1; bus_wdata = 32'h100; bus_wr = 1; eng_done = 1;
    @(negedge clk); bus_wr = 0; eng_done = 0;
    rd(1, d); check("R12 set wins", d, 32'h2100);

    check("R13 latched not enabled", irq, 0);
    for (int e = 0; e < 64; e++) begin
      logic [31:0] en;
      en = {18'd0, e[5], e[4], 2'd0, e[3], e[2], 3'd0, e[1], 3'd0, e[0]};
      wr(0, en);
      check("R13 irq sweep", irq, |(en & 32'h2100));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule